// File: doc/BRIEF.md
# Banded Column Histogram with Overlap Product

This block sits after the threshold stage of a lane-marking detector working on a top-down road image. Each clock it takes at most one pixel from two binary masks: one marks strong positive filter responses, the other strong negative ones. The block splits the raster into bands of `LINES` consecutive lines, each `COLS` columns wide. For each column it counts how many pixels in the band are set, and it does this for each mask separately.

There are two histogram banks, and they swap roles at every band boundary. While one bank collects the current band, the other bank streams out the finished band, one column per clock, and clears each entry as it reads it. On that readout path the positive count is shifted back by `SHIFT` columns to line it up with the negative count. The two counts are then multiplied. Columns where a bright strip sits next to a dark strip therefore get a large score. Downstream peak picking uses this score stream.

The first valid pixel after reset belongs to column 0 of line 0. From then on, the block derives every band boundary from its own column and line counters.

Top module: `band_hist_overlap`

## Requirements
- R1: While reset is held, and after it until the first band is complete, `score_valid` is 0 and `score` is 0.
- R2: Pixels are taken in raster order, only in cycles with `pix_valid`=1. Column runs 0..COLS-1 and then wraps to the next line. After LINES lines the band is complete.
- R3: For readout column c >= SHIFT, `score` = N[c] * P[c-SHIFT]. N[c] is the number of lines in the band with `pix_neg`=1 at column c. P[k] is the number of lines with `pix_pos`=1 at column k. Each count lies in 0..LINES, and the product is unsigned.
- R4: For readout columns c < SHIFT, `score` is 0 whatever the masks contain.
- R5: Cycles with `pix_valid`=0 have no effect on any count, whatever `pix_pos` and `pix_neg` carry.
- R6: Column c of a band is output with `score_valid`=1 exactly c+2 clock cycles after the edge that accepts the band's last pixel. The COLS beats come on consecutive cycles.
- R7: `score_first` is 1 only on the column-0 beat and `score_last` only on the column COLS-1 beat. Both are 0 when `score_valid` is 0.
- R8: Bands may follow back to back with no idle cycle. The next band accumulates while the previous one is read out, and every band produces exactly COLS beats.
- R9: Each bank entry is cleared as it is read out, so a band's scores never include pixels from an earlier band. A reset discards any partial band and restarts at column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_valid | input | 1 | A pixel is present this cycle |
| pix_pos | input | 1 | Positive-response mask bit |
| pix_neg | input | 1 | Negative-response mask bit |
| score | output | 2*CNT_W | Overlap product for the current readout column |
| score_valid | output | 1 | `score` carries a column result |
| score_first | output | 1 | Beat is column 0 of a band |
| score_last | output | 1 | Beat is column COLS-1 of a band |

## Verification
The readout of a band starts on the edge that accepts its last pixel. Column c then appears at the outputs c+2 edges later: one register on the read column and one on the product. The bench drives on falling edges and samples on falling edges. A directed test counts falling edges after the final pixel of a band: `score_valid` must be low at the first two and high at the third, together with `score_first`. A monitor advances its expected column only on valid beats, so contiguous beats, flag positions and per-band totals are all checked against the same column count.

// File: rtl/lane_hist_pkg.sv
package lane_hist_pkg;

  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } beat_t;

  function automatic int unsigned count_width(input int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/band_sequencer.sv
module band_sequencer #(
  parameter int unsigned COLS  = 32,
  parameter int unsigned LINES = 18,
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  output logic [COL_W-1:0] wr_col,
  output logic             wr_bank,
  output logic             rd_active,
  output logic [COL_W-1:0] rd_col,
  output logic             rd_bank,
  output logic             rd_first,
  output logic             rd_last
);

  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic [COL_W-1:0]  col_q, col_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              wr_bank_q, wr_bank_d;
  logic              rd_act_q, rd_act_d;
  logic [COL_W-1:0]  rd_col_q, rd_col_d;
  logic              rd_bank_q, rd_bank_d;
  logic              band_done;

  always_comb begin
    band_done = pix_valid && (col_q == COL_LAST) && (line_q == LINE_LAST);
    col_d     = col_q;
    line_d    = line_q;
    wr_bank_d = wr_bank_q;
    if (pix_valid) begin
      if (col_q == COL_LAST) begin
        col_d  = '0;
        line_d = (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
    if (band_done) wr_bank_d = ~wr_bank_q;
  end

  always_comb begin
    rd_act_d  = rd_act_q;
    rd_col_d  = rd_col_q;
    rd_bank_d = rd_bank_q;
    if (band_done) begin
      rd_act_d  = 1'b1;
      rd_col_d  = '0;
      rd_bank_d = wr_bank_q;
    end else if (rd_act_q) begin
      if (rd_col_q == COL_LAST) begin
        rd_act_d = 1'b0;
        rd_col_d = '0;
      end else begin
        rd_col_d = rd_col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      line_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_act_q  <= 1'b0;
      rd_col_q  <= '0;
      rd_bank_q <= 1'b0;
    end else begin
      col_q     <= col_d;
      line_q    <= line_d;
      wr_bank_q <= wr_bank_d;
      rd_act_q  <= rd_act_d;
      rd_col_q  <= rd_col_d;
      rd_bank_q <= rd_bank_d;
    end
  end

  assign wr_col    = col_q;
  assign wr_bank   = wr_bank_q;
  assign rd_active = rd_act_q;
  assign rd_col    = rd_col_q;
  assign rd_bank   = rd_bank_q;
  assign rd_first  = rd_act_q && (rd_col_q == '0);
  assign rd_last   = rd_act_q && (rd_col_q == COL_LAST);

  AST_NO_READ_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    band_done |-> !rd_act_q) else $error("readout still busy at band end"); // R8

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q <= COL_LAST) && (line_q <= LINE_LAST)) else $error("position out of range"); // R2

  AST_READ_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act_q) |-> (rd_col_q == '0)) else $error("readout did not start at column 0"); // R6

endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int unsigned COLS    = 32,
  parameter int unsigned MAX_CNT = 18,
  localparam int unsigned COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned CNT_W = $clog2(MAX_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [COL_W-1:0] inc_col,
  input  logic             inc_pos,
  input  logic             inc_neg,
  input  logic             clr_en,
  input  logic [COL_W-1:0] rd_col,
  output logic [CNT_W-1:0] rd_pos,
  output logic [CNT_W-1:0] rd_neg
);

  logic [CNT_W-1:0] pos_q [COLS];
  logic [CNT_W-1:0] neg_q [COLS];
  logic [CNT_W-1:0] pos_d [COLS];
  logic [CNT_W-1:0] neg_d [COLS];

  always_comb begin
    for (int i = 0; i < COLS; i++) begin
      pos_d[i] = pos_q[i];
      neg_d[i] = neg_q[i];
    end
    if (inc_en) begin
      pos_d[inc_col] = pos_q[inc_col] + CNT_W'(inc_pos);
      neg_d[inc_col] = neg_q[inc_col] + CNT_W'(inc_neg);
    end
    if (clr_en) begin
      pos_d[rd_col] = '0;
      neg_d[rd_col] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < COLS; i++) begin
        pos_q[i] <= '0;
        neg_q[i] <= '0;
      end
    end else if (inc_en || clr_en) begin
      for (int i = 0; i < COLS; i++) begin
        pos_q[i] <= pos_d[i];
        neg_q[i] <= neg_d[i];
      end
    end
  end

  assign rd_pos = pos_q[rd_col];
  assign rd_neg = neg_q[rd_col];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |-> (pos_q[inc_col] < CNT_W'(MAX_CNT)) && (neg_q[inc_col] < CNT_W'(MAX_CNT)))
    else $error("column count would exceed band height"); // R3

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (pos_q[$past(rd_col)] == '0) && (neg_q[$past(rd_col)] == '0))
    else $error("entry not cleared after readout"); // R9

  AST_NO_SHARED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_en && clr_en)) else $error("bank written and read in same cycle"); // R8

endmodule

// File: rtl/overlap_mult.sv
module overlap_mult #(
  parameter int unsigned COLS  = 32,
  parameter int unsigned CNT_W = 5,
  parameter int unsigned SHIFT = 8,
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned PROD_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_active,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_first,
  input  logic              rd_last,
  input  logic [CNT_W-1:0]  rd_pos,
  input  logic [CNT_W-1:0]  rd_neg,
  output logic [PROD_W-1:0] score,
  output logic              score_valid,
  output logic              score_first,
  output logic              score_last
);

  import lane_hist_pkg::*;

  logic [CNT_W-1:0]  dly_q [SHIFT];
  logic [CNT_W-1:0]  dly_d [SHIFT];
  logic [CNT_W-1:0]  pos_aligned;
  logic [CNT_W-1:0]  neg1_q, pos1_q;
  beat_t             beat1_q, beat1_d, beat2_q;
  logic [PROD_W-1:0] prod_q, prod_d;

  always_comb begin
    dly_d[0] = rd_pos;
    for (int i = 1; i < SHIFT; i++) dly_d[i] = dly_q[i-1];
    pos_aligned = (rd_col >= COL_W'(SHIFT)) ? dly_q[SHIFT-1] : '0;
    beat1_d     = '{valid: rd_active, first: rd_first, last: rd_last};
    prod_d      = PROD_W'(neg1_q) * PROD_W'(pos1_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SHIFT; i++) dly_q[i] <= '0;
      neg1_q  <= '0;
      pos1_q  <= '0;
      beat1_q <= '0;
      beat2_q <= '0;
      prod_q  <= '0;
    end else begin
      beat1_q <= beat1_d;
      beat2_q <= beat1_q;
      if (rd_active) begin
        for (int i = 0; i < SHIFT; i++) dly_q[i] <= dly_d[i];
        neg1_q <= rd_neg;
        pos1_q <= pos_aligned;
      end
      if (beat1_q.valid) prod_q <= prod_d;
    end
  end

  assign score       = prod_q;
  assign score_valid = beat2_q.valid;
  assign score_first = beat2_q.first;
  assign score_last  = beat2_q.last;

  AST_LEAD_COLUMNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && score_first) |-> (score == '0)) else $error("column 0 score not zero"); // R4

  AST_BEATS_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && !score_first) |-> $past(score_valid)) else $error("gap inside readout"); // R6

  AST_LAST_ENDS_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && score_last) |=> !score_valid) else $error("beat after last column"); // R7

  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (score_first || score_last) |-> score_valid) else $error("flag without valid"); // R7

endmodule

// File: rtl/band_hist_overlap.sv
module band_hist_overlap #(
  parameter int unsigned COLS  = 32,
  parameter int unsigned LINES = 18,
  parameter int unsigned SHIFT = 8,
  localparam int unsigned COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int unsigned CNT_W  = $clog2(LINES + 1),
  localparam int unsigned PROD_W = 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic              pix_pos,
  input  logic              pix_neg,
  output logic [PROD_W-1:0] score,
  output logic              score_valid,
  output logic              score_first,
  output logic              score_last
);

  logic             rst_meta_q, rst_sync_q;
  logic [COL_W-1:0] wr_col;
  logic             wr_bank;
  logic             rd_active, rd_bank, rd_first, rd_last;
  logic [COL_W-1:0] rd_col;
  logic [CNT_W-1:0] bank_pos [2];
  logic [CNT_W-1:0] bank_neg [2];
  logic [CNT_W-1:0] sel_pos, sel_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  band_sequencer #(.COLS(COLS), .LINES(LINES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .pix_valid (pix_valid),
    .wr_col    (wr_col),
    .wr_bank   (wr_bank),
    .rd_active (rd_active),
    .rd_col    (rd_col),
    .rd_bank   (rd_bank),
    .rd_first  (rd_first),
    .rd_last   (rd_last)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    hist_bank #(.COLS(COLS), .MAX_CNT(LINES)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .inc_en  (pix_valid && (wr_bank == 1'(b))),
      .inc_col (wr_col),
      .inc_pos (pix_pos),
      .inc_neg (pix_neg),
      .clr_en  (rd_active && (rd_bank == 1'(b))),
      .rd_col  (rd_col),
      .rd_pos  (bank_pos[b]),
      .rd_neg  (bank_neg[b])
    );
  end

  always_comb begin
    sel_pos = bank_pos[rd_bank];
    sel_neg = bank_neg[rd_bank];
  end

  overlap_mult #(.COLS(COLS), .CNT_W(CNT_W), .SHIFT(SHIFT)) u_ovl (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .rd_active   (rd_active),
    .rd_col      (rd_col),
    .rd_first    (rd_first),
    .rd_last     (rd_last),
    .rd_pos      (sel_pos),
    .rd_neg      (sel_neg),
    .score       (score),
    .score_valid (score_valid),
    .score_first (score_first),
    .score_last  (score_last)
  );

  AST_BANKS_APART: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rd_active |-> (rd_bank != wr_bank)) else $error("read and write on same bank"); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_q |-> !score_valid) else $error("output valid during reset"); // R1

endmodule

// File: tb/band_hist_overlap_bench.sv
module band_hist_overlap_bench;

  localparam int COLS  = 32;
  localparam int LINES = 18;
  localparam int SHIFT = 8;
  localparam int NVEC  = 8;

  // each entry: {gap, positive pattern, negative pattern}
  localparam logic [11:0] VEC [NVEC+1] = '{
    12'h011, 12'h331, 12'h001, 12'h224,
    12'h066, 12'h553, 12'h042, 12'h175,
    12'h011
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_valid = 1'b0, pix_pos = 1'b0, pix_neg = 1'b0;
  logic [9:0] score;
  logic       score_valid, score_first, score_last;

  int n_checks = 0;
  int n_bad = 0;
  int out_col = 0;
  int out_band = 0;
  bit mon_on = 1'b0;

  always #10 clk = ~clk;

  band_hist_overlap #(.COLS(COLS), .LINES(LINES), .SHIFT(SHIFT)) u_band_hist_overlap (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_pos(pix_pos), .pix_neg(pix_neg),
    .score(score), .score_valid(score_valid), .score_first(score_first), .score_last(score_last)
  );

  function automatic bit pix(input int pat, input int line, input int col);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (col % 4) == 0;
      3: return line < (col % 19);
      4: return ((line + col) % 3) == 0;
      5: return col >= COLS - 4;
      6: return ((line * 7 + col * 3) % 5) < 2;
      default: return ((line % 2) == 0) && (col >= SHIFT);
    endcase
  endfunction

  function automatic int cnt(input int pat, input int col);
    int s = 0;
    for (int l = 0; l < LINES; l++) s += pix(pat, l, col);
    return s;
  endfunction

  function automatic int exp_score(input int vi, input int col);
    int p = 0;
    if (col >= SHIFT) p = cnt(int'(VEC[vi][7:4]), col - SHIFT);
    return cnt(int'(VEC[vi][3:0]), col) * p;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drive(input bit v, input bit p, input bit n);
    pix_valid = v; pix_pos = p; pix_neg = n;
    @(negedge clk);
  endtask

  task automatic feed_band(input int vi, input int nlines);
    int gap = int'(VEC[vi][11:8]);
    for (int l = 0; l < nlines; l++)
      for (int c = 0; c < COLS; c++) begin
        if (gap != 0 && (c % gap) == 0) drive(1'b0, 1'b1, 1'b1); // R5 ignored cycle
        drive(1'b1, pix(int'(VEC[vi][7:4]), l, c), pix(int'(VEC[vi][3:0]), l, c));
      end
  endtask

  // monitor: every valid beat against the model (R3, R4, R7, R8, R9)
  always @(negedge clk) begin
    if (!rst_n) out_col = 0;
    else if (mon_on && score_valid) begin
      check(int'(score) == exp_score(out_band, out_col),
            (out_col < SHIFT) ? "R4 score" : "R3 score", int'(score), exp_score(out_band, out_col));
      check(score_first == (out_col == 0), "R7 first flag", int'(score_first), int'(out_col == 0));
      check(score_last == (out_col == COLS - 1), "R7 last flag", int'(score_last), int'(out_col == COLS - 1));
      out_col++;
      if (out_col == COLS) begin out_col = 0; out_band++; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(score_valid == 1'b0, "R1 valid in reset", int'(score_valid), 0);
    check(score == '0, "R1 score in reset", int'(score), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(score_valid == 1'b0, "R1 valid after reset", int'(score_valid), 0);
    check(score == '0, "R1 score after reset", int'(score), 0);
    mon_on = 1'b1;

    // table walk: back-to-back bands, R2 R3 R5 R8 R9
    for (int vi = 0; vi < NVEC; vi++) feed_band(vi, LINES);

    // R6 latency after the final band's last pixel edge
    pix_valid = 1'b0; pix_pos = 1'b1; pix_neg = 1'b1;
    check(score_valid == 1'b0, "R6 edge+0", int'(score_valid), 0);
    @(negedge clk);
    check(score_valid == 1'b0, "R6 edge+1", int'(score_valid), 0);
    @(negedge clk);
    check(score_valid == 1'b1 && score_first == 1'b1, "R6 edge+2", int'(score_valid), 1);
    repeat (COLS + 4) @(negedge clk);
    check(out_band == NVEC, "R8 band count", out_band, NVEC);
    check(out_col == 0, "R6 beats per band", out_col, 0);

    // R9: partial band then reset, then one full band
    feed_band(1, 5);
    rst_n = 1'b0;
    @(negedge clk);
    check(score_valid == 1'b0, "R1 valid in second reset", int'(score_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    feed_band(NVEC, LINES);
    drive(1'b0, 1'b0, 1'b0);
    repeat (COLS + 4) @(negedge clk);
    check(out_band == NVEC + 1, "R9 band after reset", out_band, NVEC + 1);

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule